// File: doc/BRIEF.md
# Aligned Pair Dual-Issue Controller

This block sits between instruction decode and the execution units of a two-wide in-order core. Each cycle it receives two pre-decoded instruction descriptors and a flag that says whether the first one starts at an 8-byte aligned address. It decides which of them may issue in this cycle and hands out the core's four execution resources: two interchangeable ALUs, one data-cache port and one multiply/divide unit. The decision is combinational on the inputs. The only state is a small per-register scoreboard that records load results still in flight.

The two instructions form a pair only when the first is aligned. A pair is split, and the second instruction waits, in four cases: the second reads a register the first writes; both need the cache port; both need the multiply/divide unit; or either one is a multi-resource operation. The first slot stalls when one of its sources is still waiting on a load. When that happens the second slot is held as well. The fetch side re-presents a held instruction on the next cycle.

Top module: `dual_issue_ctrl`

## Requirements
- R1: After reset the scoreboard is empty. With no valid instruction, `issue0`, `issue1`, `stall` and both grant vectors are 0. A valid ALU instruction in slot 0 then issues at once.
- R2: When `pair_aligned` is 1 and both slots hold independent ALU-class instructions (class code 0), both issue with `stall` 0. Slot 0 gets ALU A and slot 1 gets ALU B. The grant bit order is [0] ALU A, [1] ALU B, [2] cache port, [3] mul/div.
- R3: When `pair_aligned` is 0, slot 1 never issues and never raises `stall`. Slot 0 issues alone.
- R4: Slot 1 is held, with `stall` 1, when slot 0 writes (`s0_wr`=1) a nonzero register that slot 1 reads. Register 0 never creates a dependency.
- R5: Two memory-class instructions (class code 1) in one pair never issue together. Only slot 0 gets the cache port.
- R6: Two mul/div-class instructions (class code 2) in one pair never issue together. Only slot 0 gets the mul/div unit.
- R7: A multi-class instruction (class code 4, and class codes 5 to 7 treated as unknown) always issues alone. In slot 0 it is granted all four resources. In slot 1 it is held.
- R8: A load (class 1 with the load flag set and `wr`=1) that issues from either slot to register d makes any instruction reading d stall in the two following cycles. Such an instruction issues in the third cycle after the load.
- R9: Whenever slot 0 cannot issue, slot 1 does not issue and `stall` is 1.
- R10: A branch (class code 3) takes an ALU like an ALU-class instruction. Pairs that need different units, such as memory with mul/div or ALU with branch, issue together.
- R11: A store (class 1 with the load flag clear) leaves the scoreboard unchanged. A following reader of its register number issues at once.
- R12: When `s0_valid` is 0, nothing issues and `stall` is 0, whatever slot 1 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pair_aligned | input | 1 | Slot 0 starts at an 8-byte aligned address |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 3 | Slot 0 class code |
| s0_load | input | 1 | Slot 0 memory op is a load |
| s0_dst | input | 5 | Slot 0 destination register |
| s0_wr | input | 1 | Slot 0 writes its destination |
| s0_srca | input | 5 | Slot 0 first source register |
| s0_srcb | input | 5 | Slot 0 second source register |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 3 | Slot 1 class code |
| s1_load | input | 1 | Slot 1 memory op is a load |
| s1_dst | input | 5 | Slot 1 destination register |
| s1_wr | input | 1 | Slot 1 writes its destination |
| s1_srca | input | 5 | Slot 1 first source register |
| s1_srcb | input | 5 | Slot 1 second source register |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| stall | output | 1 | A valid instruction is held this cycle |
| grant0 | output | 4 | Resources granted to slot 0 |
| grant1 | output | 4 | Resources granted to slot 1 |

## Verification
The bench builds the block with its default parameters: 5-bit register numbers, which gives a 32-entry scoreboard, and a load latency of 3. With these values the full two-cycle shadow after a load can be walked cycle by cycle, both when the load issues from slot 0 and when it issues from slot 1. The 32-entry scoreboard leaves enough distinct registers for each scenario to use its own load targets without interference. Register 0 can be used to show that the zero register never creates a hazard.

// File: rtl/dic_pkg.sv
`timescale 1ns/1ps
package dic_pkg;
  typedef enum logic [2:0] {
    CL_ALU   = 3'd0,
    CL_MEM   = 3'd1,
    CL_MUL   = 3'd2,
    CL_BR    = 3'd3,
    CL_MULTI = 3'd4
  } op_cls_e;

  localparam int GW      = 4;
  localparam int GB_ALUA = 0;
  localparam int GB_ALUB = 1;
  localparam int GB_DC   = 2;
  localparam int GB_MD   = 3;

  function automatic logic cls_multi(input logic [2:0] c);
    return c >= 3'd4;
  endfunction

  function automatic logic cls_alu(input logic [2:0] c);
    return (c == CL_ALU) || (c == CL_BR);
  endfunction
endpackage

// File: rtl/dic_scoreboard.sv
`timescale 1ns/1ps
module dic_scoreboard #(
  parameter int REG_W    = 5,
  parameter int LOAD_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    set_en,
  input  logic [REG_W-1:0]        set_reg,
  output logic [(1<<REG_W)-1:0]   pending
);
  localparam int NREGS = 1 << REG_W;
  localparam int CW    = (LOAD_LAT > 2) ? $clog2(LOAD_LAT) : 1;
  localparam int HOLD  = LOAD_LAT - 1;

  assign pending[0] = 1'b0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit, cnt_en;

    always_comb begin
      hit    = set_en && (set_reg == REG_W'(g));
      cnt_en = hit || (cnt_q != '0);
      cnt_d  = cnt_q;
      if (hit)              cnt_d = CW'(HOLD);
      else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign pending[g] = (cnt_q != '0);
  end

  // R8: a recorded load keeps its register busy in the next cycle
  assert_load_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_reg != '0) |=> pending[$past(set_reg)]);
endmodule

// File: rtl/dic_pair_check.sv
`timescale 1ns/1ps
module dic_pair_check
  import dic_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  aligned,
  input  logic                  v0,
  input  logic [2:0]            c0,
  input  logic [REG_W-1:0]      d0,
  input  logic                  w0,
  input  logic [REG_W-1:0]      a0,
  input  logic [REG_W-1:0]      b0,
  input  logic                  v1,
  input  logic [2:0]            c1,
  input  logic [REG_W-1:0]      a1,
  input  logic [REG_W-1:0]      b1,
  input  logic [(1<<REG_W)-1:0] pending,
  output logic                  iss0,
  output logic                  iss1,
  output logic                  stall
);
  logic haz0, haz1, raw, clash, pair_ok;

  always_comb begin
    haz0    = pending[a0] || pending[b0];
    haz1    = pending[a1] || pending[b1];
    raw     = w0 && (d0 != '0) && ((a1 == d0) || (b1 == d0));
    clash   = cls_multi(c0) || cls_multi(c1)
            || ((c0 == CL_MEM) && (c1 == CL_MEM))
            || ((c0 == CL_MUL) && (c1 == CL_MUL));
    iss0    = v0 && !haz0;
    pair_ok = aligned && v1 && !raw && !clash && !haz1;
    iss1    = iss0 && pair_ok;
    stall   = v0 && (!iss0 || (aligned && v1 && !iss1));
  end

  // R3: the second slot only issues from an aligned pair
  assert_pair_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> aligned);
  // R9: the second slot never overtakes the first
  assert_in_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> iss0);
  // R8: nothing issues from slot 0 while a source is pending
  assert_no_early_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss0 |-> !(pending[a0] || pending[b0]));
  // R7: a multi-class op never shares the cycle
  assert_multi_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0 && cls_multi(c0)) |-> !iss1);
endmodule

// File: rtl/dic_grant.sv
`timescale 1ns/1ps
module dic_grant
  import dic_pkg::*;
(
  input  logic          iss,
  input  logic [2:0]    cls,
  input  logic          alua_taken,
  output logic [GW-1:0] grant
);
  always_comb begin
    grant = '0;
    if (iss) begin
      if (cls_multi(cls)) grant = '1;
      else if (cls_alu(cls)) begin
        if (alua_taken) grant[GB_ALUB] = 1'b1;
        else            grant[GB_ALUA] = 1'b1;
      end
      else if (cls == CL_MEM) grant[GB_DC] = 1'b1;
      else                    grant[GB_MD] = 1'b1;
    end
  end
endmodule

// File: rtl/dual_issue_ctrl.sv
`timescale 1ns/1ps
module dual_issue_ctrl
  import dic_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int LOAD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_aligned,
  input  logic             s0_valid,
  input  logic [2:0]       s0_cls,
  input  logic             s0_load,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s0_wr,
  input  logic [REG_W-1:0] s0_srca,
  input  logic [REG_W-1:0] s0_srcb,
  input  logic             s1_valid,
  input  logic [2:0]       s1_cls,
  input  logic             s1_load,
  input  logic [REG_W-1:0] s1_dst,
  input  logic             s1_wr,
  input  logic [REG_W-1:0] s1_srca,
  input  logic [REG_W-1:0] s1_srcb,
  output logic             issue0,
  output logic             issue1,
  output logic             stall,
  output logic [GW-1:0]    grant0,
  output logic [GW-1:0]    grant1
);
  localparam int NREGS = 1 << REG_W;

  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic [NREGS-1:0] pending;
  logic             ld0, ld1, set_en;
  logic [REG_W-1:0] set_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    ld0     = issue0 && (s0_cls == CL_MEM) && s0_load && s0_wr;
    ld1     = issue1 && (s1_cls == CL_MEM) && s1_load && s1_wr;
    set_en  = ld0 || ld1;
    set_reg = ld1 ? s1_dst : s0_dst;
  end

  dic_scoreboard #(.REG_W(REG_W), .LOAD_LAT(LOAD_LAT)) u_sb (
    .clk(clk), .rst_n(rst_sync_n), .set_en(set_en), .set_reg(set_reg),
    .pending(pending));

  dic_pair_check #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_sync_n), .aligned(pair_aligned),
    .v0(s0_valid), .c0(s0_cls), .d0(s0_dst), .w0(s0_wr),
    .a0(s0_srca), .b0(s0_srcb),
    .v1(s1_valid), .c1(s1_cls), .a1(s1_srca), .b1(s1_srcb),
    .pending(pending), .iss0(issue0), .iss1(issue1), .stall(stall));

  dic_grant u_g0 (.iss(issue0), .cls(s0_cls), .alua_taken(1'b0), .grant(grant0));
  dic_grant u_g1 (.iss(issue1), .cls(s1_cls), .alua_taken(grant0[GB_ALUA]),
                  .grant(grant1));

  // R5: the cache port is never granted to both slots
  assert_one_dcache_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({grant0[GB_DC], grant1[GB_DC]}));
  // R6: the mul/div unit is never granted to both slots
  assert_one_muldiv_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({grant0[GB_MD], grant1[GB_MD]}));
  // R2: each ALU goes to at most one slot
  assert_alu_split_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({grant0[GB_ALUA], grant1[GB_ALUA]}) && $onehot0({grant0[GB_ALUB], grant1[GB_ALUB]}));
  // R12: no issue without a valid first slot
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s0_valid |-> (!issue0 && !issue1 && !stall));
endmodule

// File: tb/dual_issue_ctrl_bench.sv
`timescale 1ns/1ps
module dual_issue_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic pair_aligned;
  logic s0_valid, s0_load, s0_wr, s1_valid, s1_load, s1_wr;
  logic [2:0] s0_cls, s1_cls;
  logic [4:0] s0_dst, s0_srca, s0_srcb, s1_dst, s1_srca, s1_srcb;
  logic issue0, issue1, stall;
  logic [3:0] grant0, grant1;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_issue_ctrl u_dual_issue_ctrl (.*);

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic put0(input bit v, input int c, input bit ld, input int d,
                      input bit w, input int a, input int b);
    s0_valid = v; s0_cls = 3'(c); s0_load = ld; s0_dst = 5'(d);
    s0_wr = w; s0_srca = 5'(a); s0_srcb = 5'(b);
  endtask

  task automatic put1(input bit v, input int c, input bit ld, input int d,
                      input bit w, input int a, input int b);
    s1_valid = v; s1_cls = 3'(c); s1_load = ld; s1_dst = 5'(d);
    s1_wr = w; s1_srca = 5'(a); s1_srcb = 5'(b);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    put0(0, 0, 0, 0, 0, 0, 0); put1(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    idle(0); pair_aligned = 1; #1;
    chk("R1 idle issue0", issue0, 0); chk("R1 idle stall", stall, 0);
    chk("R1 idle grants", {grant1, grant0}, 0);
    put0(1, 0, 0, 5, 1, 5, 6); #1;
    chk("R1 first alu issues", issue0, 1);
    step(); idle(1);
  endtask

  task automatic t_pair_alu();
    pair_aligned = 1;
    put0(1, 0, 0, 1, 1, 2, 3); put1(1, 0, 0, 4, 1, 5, 6); #1;
    chk("R2 issue0", issue0, 1); chk("R2 issue1", issue1, 1);
    chk("R2 stall", stall, 0);
    chk("R2 grant0", grant0, 4'b0001); chk("R2 grant1", grant1, 4'b0010);
    step(); idle(1);
  endtask

  task automatic t_unaligned();
    pair_aligned = 0;
    put0(1, 0, 0, 1, 1, 2, 3); put1(1, 0, 0, 4, 1, 5, 6); #1;
    chk("R3 issue0", issue0, 1); chk("R3 issue1", issue1, 0);
    chk("R3 stall", stall, 0); chk("R3 grant1", grant1, 0);
    step(); idle(1);
  endtask

  task automatic t_raw();
    pair_aligned = 1;
    put0(1, 0, 0, 3, 1, 1, 2); put1(1, 0, 0, 4, 1, 7, 3); #1;
    chk("R4 raw issue0", issue0, 1); chk("R4 raw issue1", issue1, 0);
    chk("R4 raw stall", stall, 1);
    step();
    pair_aligned = 0; put0(1, 0, 0, 4, 1, 7, 3); put1(0, 0, 0, 0, 0, 0, 0); #1;
    chk("R4 held re-presented issues", issue0, 1);
    step();
    pair_aligned = 1;
    put0(1, 0, 0, 0, 1, 1, 2); put1(1, 0, 0, 4, 1, 0, 0); #1;
    chk("R4 r0 no dependency", issue1, 1);
    put0(1, 0, 0, 3, 0, 1, 2); put1(1, 0, 0, 4, 1, 3, 3); #1;
    chk("R4 no write no dependency", issue1, 1);
    step(); idle(1);
  endtask

  task automatic t_mem_mem();
    pair_aligned = 1;
    put0(1, 1, 0, 20, 0, 1, 2); put1(1, 1, 0, 21, 0, 3, 4); #1;
    chk("R5 issue1", issue1, 0); chk("R5 stall", stall, 1);
    chk("R5 grant0", grant0, 4'b0100); chk("R5 grant1", grant1, 0);
    step(); idle(1);
  endtask

  task automatic t_mul_mul();
    pair_aligned = 1;
    put0(1, 2, 0, 1, 1, 2, 3); put1(1, 2, 0, 4, 1, 5, 6); #1;
    chk("R6 issue1", issue1, 0); chk("R6 stall", stall, 1);
    chk("R6 grant0", grant0, 4'b1000);
    step(); idle(1);
  endtask

  task automatic t_multi();
    pair_aligned = 1;
    put0(1, 4, 0, 1, 1, 2, 3); put1(1, 0, 0, 4, 1, 5, 6); #1;
    chk("R7 slot0 multi grant", grant0, 4'b1111);
    chk("R7 slot0 multi alone", issue1, 0); chk("R7 stall", stall, 1);
    put0(1, 0, 0, 1, 1, 2, 3); put1(1, 7, 0, 4, 1, 5, 6); #1;
    chk("R7 unknown slot1 held", issue1, 0);
    chk("R7 alu slot0 issues", issue0, 1);
    step(); idle(1);
  endtask

  task automatic t_load_shadow();
    pair_aligned = 0;
    put0(1, 1, 1, 9, 1, 1, 2); put1(0, 0, 0, 0, 0, 0, 0); #1;
    chk("R8 load issues", issue0, 1);
    step();
    put0(1, 0, 0, 11, 1, 9, 2); #1;
    chk("R8 cycle+1 held", issue0, 0); chk("R8 cycle+1 stall", stall, 1);
    step(); #1;
    chk("R8 cycle+2 held", issue0, 0);
    step(); #1;
    chk("R8 cycle+3 issues", issue0, 1);
    step(); idle(1);
    pair_aligned = 1;
    put0(1, 0, 0, 1, 1, 2, 3); put1(1, 1, 1, 14, 1, 5, 6); #1;
    chk("R8 slot1 load pairs", issue1, 1);
    step();
    pair_aligned = 0; put1(0, 0, 0, 0, 0, 0, 0);
    put0(1, 0, 0, 2, 1, 3, 14); #1;
    chk("R8 slot1 load shadow", issue0, 0);
    idle(3);
  endtask

  task automatic t_slot0_stall();
    pair_aligned = 0;
    put0(1, 1, 1, 10, 1, 1, 2); put1(0, 0, 0, 0, 0, 0, 0); #1;
    step();
    pair_aligned = 1;
    put0(1, 0, 0, 1, 1, 10, 2); put1(1, 0, 0, 4, 1, 5, 6); #1;
    chk("R9 issue0", issue0, 0); chk("R9 issue1", issue1, 0);
    chk("R9 stall", stall, 1); chk("R9 grants", {grant1, grant0}, 0);
    idle(3);
  endtask

  task automatic t_mixed();
    pair_aligned = 1;
    put0(1, 1, 0, 1, 0, 2, 3); put1(1, 2, 0, 4, 1, 5, 6); #1;
    chk("R10 mem+mul issue1", issue1, 1);
    chk("R10 mem+mul grant0", grant0, 4'b0100);
    chk("R10 mem+mul grant1", grant1, 4'b1000);
    put0(1, 0, 0, 1, 1, 2, 3); put1(1, 3, 0, 0, 0, 5, 6); #1;
    chk("R10 alu+branch issue1", issue1, 1);
    chk("R10 branch takes ALU B", grant1, 4'b0010);
    put0(1, 1, 0, 1, 0, 2, 3); put1(1, 3, 0, 0, 0, 5, 6); #1;
    chk("R10 branch takes ALU A", grant1, 4'b0001);
    step(); idle(1);
  endtask

  task automatic t_store();
    pair_aligned = 0;
    put0(1, 1, 0, 12, 0, 1, 2); #1;
    chk("R11 store issues", issue0, 1);
    step();
    put0(1, 0, 0, 3, 1, 12, 12); #1;
    chk("R11 no shadow after store", issue0, 1);
    step(); idle(1);
  endtask

  task automatic t_no_slot0();
    pair_aligned = 1;
    put0(0, 0, 0, 1, 1, 2, 3); put1(1, 0, 0, 4, 1, 5, 6); #1;
    chk("R12 issue0", issue0, 0); chk("R12 issue1", issue1, 0);
    chk("R12 stall", stall, 0);
    step(); idle(1);
  endtask

  initial begin
    rst_n = 0; pair_aligned = 0;
    put0(0, 0, 0, 0, 0, 0, 0); put1(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset(); t_pair_alu(); t_unaligned(); t_raw(); t_mem_mem();
    t_mul_mul(); t_multi(); t_load_shadow(); t_slot0_stall();
    t_mixed(); t_store(); t_no_slot0();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule